// File: doc/BRIEF.md
# Cartridge bank-switching address mapper

This block turns a 20-bit CPU memory address into a cartridge address and a chip select. Above the first 64 KiB, the address space splits into windows. The top twelve 64 KiB pages form a linear ROM window, banked in 1 MiB units by a narrow register. The three pages below it are each banked in 64 KiB units by a wider register: one page for RAM and two for ROM.

Software sets the bank registers over an 8-bit I/O port bus. Each 64 KiB bank register has two access paths:
- a short legacy port that reaches only its low byte;
- an extended port that reaches the whole register, either as one 16-bit access or as two byte accesses.

A control bit lets the RAM page point at ROM, so that a flash part used as ROM can be written through that page. Every access that falls in the RAM page is flagged as byte-wide.

The address translation is purely combinational. Register writes take effect at the clock edge that samples the write strobe.

Top module: `cart_bank_mapper`

## Requirements
- R1: After reset, every bank register and the remap bit are zero, and every mapped port reads back 0.
- R2: For CPU addresses 0x40000–0xFFFFF with `cpu_en` high, `rom_cs`=1, `ram_cs`=0 and `rom_addr` = {linear bank (6 bits), cpu_addr[19:0]}.
- R3: For pages 0x2xxxx and 0x3xxxx, `rom_cs`=1 and `rom_addr` = {ROM-A or ROM-B bank (10 bits), cpu_addr[15:0]}, respectively.
- R4: With the remap bit at 0, page 0x1xxxx gives `ram_cs`=1, `rom_cs`=0 and `ram_addr` = {RAM bank, cpu_addr[15:0]}.
- R5: With the remap bit at 1, page 0x1xxxx gives `rom_cs`=1, `ram_cs`=0 and `rom_addr` = {RAM bank, cpu_addr[15:0]}. The two selects are never high together.
- R6: `byte_mode` is 1 exactly for enabled accesses in page 0x1xxxx, whichever chip is selected there.
- R7: Addresses below 0x10000, or any address while `cpu_en` is 0, assert neither chip select.
- R8: Port map, at offsets from IO_BASE (default 0x40):
  - +0 is the legacy linear port; +1, +2 and +3 are the legacy ports for the RAM, ROM-A and ROM-B banks.
  - A legacy write changes only bits [7:0] of its bank and keeps bits [9:8].
  - A legacy read returns bits [7:0].
- R9: The extended ports sit at +6 (RAM), +8 (ROM-A) and +10 (ROM-B).
  - A 16-bit access (`io_wide`=1) at one of these offsets writes or reads all 10 bits, and bits [15:10] read as zero.
  - A byte access at offset+1 reaches bits [9:8] through data bits [1:0].
  - The extended linear port at +5 shares its storage with +0.
- R10: The remap control port at +4 stores only data bit 0 and reads as 0x0001 or 0x0000.
- R11: Writes to unmapped port addresses change no register, and reads of them return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| io_addr | input | 8 | I/O port address |
| io_wr | input | 1 | I/O write strobe |
| io_wide | input | 1 | 1 = 16-bit access, 0 = byte access |
| io_wdata | input | 16 | I/O write data |
| io_rdata | output | 16 | I/O read data (combinational) |
| cpu_en | input | 1 | Memory access in progress |
| cpu_addr | input | 20 | CPU memory address |
| rom_cs | output | 1 | ROM chip select |
| ram_cs | output | 1 | RAM chip select |
| byte_mode | output | 1 | Access is byte-wide |
| rom_addr | output | 26 | Banked ROM address |
| ram_addr | output | 26 | Banked RAM address |

## Verification
The bench checks that a legacy byte write keeps the upper two bank bits. A design that aliased the full width would clear them and send later accesses to a far lower bank.

It remaps the RAM page onto ROM and checks three things there: the chip select swaps, the RAM bank still supplies the upper address, and `byte_mode` stays high. A design that forgot the remap would write flash contents into RAM.

It probes the window edges 0x0FFFF, 0x10000, 0x3FFFF, 0x40000 and 0xFFFFF, where an off-by-one page decode would select the wrong chip. It also hits unmapped ports and the control port with all bits set. A loose port decode would corrupt a bank register, or stray control bits would read back.

// File: rtl/cart_bank_mapper.sv
module cart_bank_mapper #(
  parameter int LIN_W   = 6,
  parameter int BANK_W  = 10,
  parameter int IO_BASE = 8'h40
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [7:0]          io_addr,
  input  logic                io_wr,
  input  logic                io_wide,
  input  logic [15:0]         io_wdata,
  output logic [15:0]         io_rdata,
  input  logic                cpu_en,
  input  logic [19:0]         cpu_addr,
  output logic                rom_cs,
  output logic                ram_cs,
  output logic                byte_mode,
  output logic [((LIN_W+20 > BANK_W+16) ? LIN_W+20 : BANK_W+16)-1:0] rom_addr,
  output logic [BANK_W+16-1:0] ram_addr
);
  localparam int HI_W   = BANK_W - 8;
  localparam int ROM_AW = (LIN_W+20 > BANK_W+16) ? LIN_W+20 : BANK_W+16;
  localparam int NBANK  = 3;
  localparam logic [7:0] A_LLIN = 8'(IO_BASE + 0);
  localparam logic [7:0] A_CTRL = 8'(IO_BASE + 4);
  localparam logic [7:0] A_XLIN = 8'(IO_BASE + 5);
  localparam int A_LEG0 = IO_BASE + 1;
  localparam int A_EXT0 = IO_BASE + 6;

  logic [LIN_W-1:0]  lin_bank;
  logic [BANK_W-1:0] bank [NBANK];
  logic              flash_sel;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lin_bank  <= '0;
      flash_sel <= 1'b0;
      for (int i = 0; i < NBANK; i++) bank[i] <= '0;
    end else if (io_wr) begin
      if (io_addr == A_LLIN || io_addr == A_XLIN) lin_bank <= io_wdata[LIN_W-1:0];
      if (io_addr == A_CTRL) flash_sel <= io_wdata[0];
      for (int i = 0; i < NBANK; i++) begin
        if (io_addr == 8'(A_LEG0 + i))
          bank[i][7:0] <= io_wdata[7:0];
        if (io_addr == 8'(A_EXT0 + 2*i)) begin
          bank[i][7:0] <= io_wdata[7:0];
          if (io_wide) bank[i][BANK_W-1:8] <= io_wdata[BANK_W-1:8];
        end
        if (io_addr == 8'(A_EXT0 + 2*i + 1))
          bank[i][BANK_W-1:8] <= io_wdata[HI_W-1:0];
      end
    end
  end

  always_comb begin
    io_rdata = '0;
    if (io_addr == A_LLIN || io_addr == A_XLIN) io_rdata = 16'(lin_bank);
    if (io_addr == A_CTRL) io_rdata = 16'(flash_sel);
    for (int i = 0; i < NBANK; i++) begin
      if (io_addr == 8'(A_LEG0 + i))         io_rdata = 16'(bank[i][7:0]);
      if (io_addr == 8'(A_EXT0 + 2*i))       io_rdata = io_wide ? 16'(bank[i]) : 16'(bank[i][7:0]);
      if (io_addr == 8'(A_EXT0 + 2*i + 1))   io_rdata = 16'(bank[i][BANK_W-1:8]);
    end
  end

  logic [3:0]        page;
  logic              win_lin, win_ram, win_rom;
  logic [BANK_W-1:0] win_bank;

  assign page    = cpu_addr[19:16];
  assign win_lin = |page[3:2];
  assign win_ram = page == 4'd1;
  assign win_rom = page == 4'd2 || page == 4'd3;

  always_comb begin
    case (page[1:0])
      2'd1:    win_bank = bank[0];
      2'd2:    win_bank = bank[1];
      default: win_bank = bank[2];
    endcase
  end

  assign rom_cs    = cpu_en && (win_lin || win_rom || (win_ram && flash_sel));
  assign ram_cs    = cpu_en && win_ram && !flash_sel;
  assign byte_mode = cpu_en && win_ram;
  assign rom_addr  = win_lin ? ROM_AW'({lin_bank, cpu_addr}) : ROM_AW'({win_bank, cpu_addr[15:0]});
  assign ram_addr  = {bank[0], cpu_addr[15:0]};
endmodule

module cart_bank_mapper_chk #(
  parameter int LIN_W   = 6,
  parameter int BANK_W  = 10,
  parameter int IO_BASE = 8'h40
) (
  input logic              clk,
  input logic              rst_n,
  input logic [7:0]        io_addr,
  input logic              io_wr,
  input logic [15:0]       io_rdata,
  input logic              cpu_en,
  input logic [19:0]       cpu_addr,
  input logic              rom_cs,
  input logic              ram_cs,
  input logic              byte_mode,
  input logic [LIN_W-1:0]  lin_q,
  input logic [BANK_W-1:0] ram_q,
  input logic              sel_q
);
  localparam logic [7:0] A_LRAM = 8'(IO_BASE + 1);
  localparam logic [7:0] A_CTRL = 8'(IO_BASE + 4);

  AST_RESET_CLEAR: assert property (@(posedge clk) $rose(rst_n) |-> (lin_q == '0 && ram_q == '0 && !sel_q)); // R1
  AST_CS_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n) !(rom_cs && ram_cs)); // R5
  AST_RAM_IS_BYTE: assert property (@(posedge clk) disable iff (!rst_n) ram_cs |-> byte_mode); // R6
  AST_LOW_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
    (!cpu_en || cpu_addr[19:16] == 4'd0) |-> (!rom_cs && !ram_cs)); // R7
  AST_LEGACY_KEEPS_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    (io_wr && io_addr == A_LRAM) |=> $stable(ram_q[BANK_W-1:8])); // R8
  AST_CTRL_ONE_BIT: assert property (@(posedge clk) disable iff (!rst_n)
    (io_addr == A_CTRL) |-> (io_rdata[15:1] == '0)); // R10
endmodule

bind cart_bank_mapper cart_bank_mapper_chk #(.LIN_W(LIN_W), .BANK_W(BANK_W), .IO_BASE(IO_BASE)) u_chk (
  .clk(clk), .rst_n(rst_n), .io_addr(io_addr), .io_wr(io_wr), .io_rdata(io_rdata),
  .cpu_en(cpu_en), .cpu_addr(cpu_addr), .rom_cs(rom_cs), .ram_cs(ram_cs),
  .byte_mode(byte_mode), .lin_q(lin_bank), .ram_q(bank[0]), .sel_q(flash_sel)
);

// File: tb/sim_cart_bank_mapper.sv
`timescale 1ns/1ps
module sim_cart_bank_mapper;
  logic        clk = 0, rst_n = 0;
  logic [7:0]  io_addr = '0;
  logic        io_wr = 0, io_wide = 0;
  logic [15:0] io_wdata = '0, io_rdata;
  logic        cpu_en = 0;
  logic [19:0] cpu_addr = '0;
  logic        rom_cs, ram_cs, byte_mode;
  logic [25:0] rom_addr, ram_addr;
  int n_cmp = 0, n_bad = 0;
  localparam logic [7:0] B = 8'h40;

  always #10 clk = ~clk;

  cart_bank_mapper u0 (.clk, .rst_n, .io_addr, .io_wr, .io_wide, .io_wdata, .io_rdata,
    .cpu_en, .cpu_addr, .rom_cs, .ram_cs, .byte_mode, .rom_addr, .ram_addr);

  task automatic chk(string req, string what, longint got, longint exp);
    n_cmp++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s %s: got 0x%0h expected 0x%0h", req, what, got, exp);
    end
  endtask

  task automatic wr(logic [7:0] a, logic [15:0] d, logic w);
    @(negedge clk);
    io_addr = a; io_wdata = d; io_wide = w; io_wr = 1;
    @(negedge clk);
    io_wr = 0; io_wide = 0;
  endtask

  task automatic rd(string req, logic [7:0] a, logic w, logic [15:0] exp);
    @(negedge clk);
    io_addr = a; io_wide = w; #1;
    chk(req, $sformatf("read port 0x%0h", a), io_rdata, exp);
    io_wide = 0;
  endtask

  task automatic mem(string req, logic en, logic [19:0] a, logic rc, logic mc, logic bm, logic [25:0] ra, logic [25:0] ma, logic ck_rom, logic ck_ram);
    @(negedge clk);
    cpu_en = en; cpu_addr = a; #1;
    chk(req, $sformatf("rom_cs @%0h", a), rom_cs, rc);
    chk(req, $sformatf("ram_cs @%0h", a), ram_cs, mc);
    chk(req, $sformatf("byte_mode @%0h", a), byte_mode, bm);
    if (ck_rom) chk(req, $sformatf("rom_addr @%0h", a), rom_addr, ra);
    if (ck_ram) chk(req, $sformatf("ram_addr @%0h", a), ram_addr, ma);
    cpu_en = 0;
  endtask

  task automatic t_reset;
    rd("R1", B+0, 0, 0); rd("R1", B+4, 0, 0); rd("R1", B+5, 0, 0);
    rd("R1", B+6, 1, 0); rd("R1", B+8, 1, 0); rd("R1", B+10, 1, 0);
    mem("R1", 1, 20'h1_0000, 0, 1, 1, 0, 26'h0, 0, 1);
  endtask

  task automatic t_alias;
    wr(B+6, 16'hFFFF, 1);
    rd("R9", B+6, 1, 16'h03FF);
    wr(B+1, 16'h005A, 0);
    rd("R8", B+6, 1, 16'h035A);
    rd("R8", B+1, 0, 16'h005A);
    wr(B+7, 16'h0002, 0);
    rd("R9", B+6, 1, 16'h025A);
    rd("R9", B+7, 0, 16'h0002);
    rd("R8", B+6, 0, 16'h005A);
  endtask

  task automatic t_linear;
    wr(B+0, 16'h002A, 0);
    rd("R9", B+5, 0, 16'h002A);
    mem("R2", 1, 20'h7_1234, 1, 0, 0, 26'h2A71234, 0, 1, 0);
    mem("R2", 1, 20'hF_FFFF, 1, 0, 0, 26'h2AFFFFF, 0, 1, 0);
    mem("R2", 1, 20'h4_0000, 1, 0, 0, 26'h2A40000, 0, 1, 0);
    wr(B+5, 16'h0015, 0);
    rd("R8", B+0, 0, 16'h0015);
    mem("R2", 1, 20'h8_0001, 1, 0, 0, 26'h1580001, 0, 1, 0);
  endtask

  task automatic t_banked;
    wr(B+8, 16'h0123, 1);
    wr(B+10, 16'h0321, 1);
    mem("R3", 1, 20'h2_ABCD, 1, 0, 0, 26'h123ABCD, 0, 1, 0);
    mem("R3", 1, 20'h3_FFFF, 1, 0, 0, 26'h321FFFF, 0, 1, 0);
    wr(B+2, 16'h00EE, 0);
    mem("R8", 1, 20'h2_0000, 1, 0, 0, 26'h1EE0000, 0, 1, 0);
  endtask

  task automatic t_ram;
    mem("R4", 1, 20'h1_0040, 0, 1, 1, 0, 26'h25A0040, 0, 1);
    mem("R6", 1, 20'h1_FFFF, 0, 1, 1, 0, 26'h25AFFFF, 0, 1);
  endtask

  task automatic t_flash;
    wr(B+4, 16'hFFFF, 1);
    rd("R10", B+4, 1, 16'h0001);
    mem("R5", 1, 20'h1_0040, 1, 0, 1, 26'h25A0040, 0, 1, 0);
    mem("R6", 1, 20'h2_0000, 1, 0, 0, 26'h1EE0000, 0, 1, 0);
    wr(B+4, 16'h00FE, 0);
    rd("R10", B+4, 0, 16'h0000);
    mem("R5", 1, 20'h1_0040, 0, 1, 1, 0, 26'h25A0040, 0, 1);
  endtask

  task automatic t_low;
    mem("R7", 1, 20'h0_FFFF, 0, 0, 0, 0, 0, 0, 0);
    mem("R7", 1, 20'h0_0000, 0, 0, 0, 0, 0, 0, 0);
    mem("R7", 0, 20'h2_ABCD, 0, 0, 0, 0, 0, 0, 0);
    mem("R7", 0, 20'h1_0000, 0, 0, 0, 0, 0, 0, 0);
  endtask

  task automatic t_unmapped;
    wr(B+12, 16'hFFFF, 1);
    wr(B+3'd3 + 8'd0 - 8'd4, 16'hFFFF, 1);
    wr(8'h3F, 16'hFFFF, 1);
    wr(8'h00, 16'hFFFF, 0);
    rd("R11", B+12, 1, 0);
    rd("R11", 8'h3F, 1, 0);
    rd("R11", B+6, 1, 16'h025A);
    rd("R11", B+8, 1, 16'h01EE);
    rd("R11", B+10, 1, 16'h0321);
    rd("R11", B+0, 0, 16'h0015);
    rd("R11", B+4, 0, 16'h0000);
  endtask

  initial begin : watchdog
    #2_000_000;
    n_cmp++; n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    t_reset;
    t_alias;
    t_linear;
    t_banked;
    t_ram;
    t_flash;
    t_low;
    t_unmapped;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule